// File: doc/BRIEF.md
# GPIO Controller with Interrupts

This block controls up to 32 general-purpose lines from a simple 32-bit register bus. Software never performs a read-modify-write on a control field. Every field has a write-one-to-set address and a write-one-to-clear address, so each line can be changed without touching the others. The stored fields are:

- output value
- drive enable (direction)
- interrupt enable
- interrupt mask
- edge/level selection
- polarity
- a dual-edge override
- a per-line debounce enable

Pins are synchronised and, where chosen, debounced. Each line is then judged against its trigger selection. Edge events are held until software acknowledges them, while level conditions simply follow the pin. A single combined interrupt output, gated by one enable bit, signals that any enabled and unmasked line is pending. Reads return data one cycle after the read strobe.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every field is 0. This means no line drives, all outputs are low, interrupts are disabled and unmasked, the type is level-low, debounce and dual-edge are off, and `irq_out` is low.
- R2: The output value is changed through 0x000 (set) and 0x004 (clear). The direction is changed through 0x010 (set) and 0x014 (clear), and a 1 means the line drives. Only bits written as 1 change; 0 bits leave the field alone. The output value appears on `pin_out` and the direction on `pin_oe`, and 0x018 reads back the direction.
- R3: With debounce off, a pin level reaches the detector and the 0x080 read value three clock edges after it is applied.
- R4: With a line's debounce bit set (0x060 set, 0x064 clear), a change must persist for DEB_CYCLES consecutive cycles after synchronisation before it is seen. A shorter glitch is never seen.
- R5: The edge bit (0x040 set, 0x044 clear) and the polarity bit (0x050 set, 0x054 clear) select the trigger. With edge=0, polarity 1 means active-high and polarity 0 means active-low, and the pending state follows the filtered pin without being latched.
- R6: With edge=1, polarity 1 latches a rising edge and polarity 0 latches a falling edge. The event stays pending until a 1 is written to the line's bit at 0x078.
- R7: The dual-edge bit (0x0B0 set, 0x0B4 clear, 0x0B8 read) makes a line latch both edges, whatever its edge and polarity bits say.
- R8: If an edge and its acknowledge arrive in the same cycle, the edge stays pending. Acknowledge bits written as 0 have no effect.
- R9: 0x070 reads pending AND enabled (0x020 set, 0x024 clear) AND NOT masked (0x030 set, 0x034 clear). Edges on disabled lines are not latched. Masking hides a latched event without discarding it.
- R10: Bit 0 of 0x0A0 is a plain read/write enable. `irq_out` is high exactly when that bit is 1 and at least one bit of the 0x070 value is 1.
- R11: `rdata` carries the addressed value in the cycle after `rd_en` and is 0 otherwise. Write-only and unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| pin_in | input | NLINES | External pin levels |
| pin_out | output | NLINES | Output value per line |
| pin_oe | output | NLINES | Drive enable per line |
| irq_out | output | 1 | Combined interrupt |

## Verification
An acknowledge write and a fresh edge on the same line can land in the same cycle. The bench provokes this by pulsing a pin and then acknowledging after every delay from zero to six cycles, so one of those delays collides with the edge reaching the detector. A behavioural model decides, cycle by cycle, whether the event must survive. Likewise, a configuration write and an edge evaluated under the old configuration can meet. In that case the model uses the pre-write settings, and every read and `irq_out` is compared on each clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_OUT_SET   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_OUT_CLR   = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_DIR_SET   = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_DIR_CLR   = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_DIR_RD    = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_EN_SET    = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_EN_CLR    = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_MSK_SET   = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_MSK_CLR   = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_EDGE_SET  = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_EDGE_CLR  = 8'h44;
    localparam logic [ADDR_W-1:0] OFF_POL_SET   = 8'h50;
    localparam logic [ADDR_W-1:0] OFF_POL_CLR   = 8'h54;
    localparam logic [ADDR_W-1:0] OFF_DEB_SET   = 8'h60;
    localparam logic [ADDR_W-1:0] OFF_DEB_CLR   = 8'h64;
    localparam logic [ADDR_W-1:0] OFF_PEND_RD   = 8'h70;
    localparam logic [ADDR_W-1:0] OFF_ACK       = 8'h78;
    localparam logic [ADDR_W-1:0] OFF_PIN_RD    = 8'h80;
    localparam logic [ADDR_W-1:0] OFF_GATE      = 8'hA0;
    localparam logic [ADDR_W-1:0] OFF_BOTH_SET  = 8'hB0;
    localparam logic [ADDR_W-1:0] OFF_BOTH_CLR  = 8'hB4;
    localparam logic [ADDR_W-1:0] OFF_BOTH_RD   = 8'hB8;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_irq_pkg::*;
#(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [NLINES-1:0] out_val,
    output logic [NLINES-1:0] drive,
    output logic [NLINES-1:0] irq_en,
    output logic [NLINES-1:0] irq_msk,
    output logic [NLINES-1:0] is_edge,
    output logic [NLINES-1:0] pol_hi,
    output logic [NLINES-1:0] deb_on,
    output logic [NLINES-1:0] both_on,
    output logic              gate_on,
    output logic [NLINES-1:0] ack
);
    typedef struct packed {
        logic [NLINES-1:0] out_val;
        logic [NLINES-1:0] drive;
        logic [NLINES-1:0] irq_en;
        logic [NLINES-1:0] irq_msk;
        logic [NLINES-1:0] is_edge;
        logic [NLINES-1:0] pol_hi;
        logic [NLINES-1:0] deb_on;
        logic [NLINES-1:0] both_on;
        logic              gate_on;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [NLINES-1:0] wbits;

    assign wbits = wdata[NLINES-1:0];

    always_comb begin
        cfg_d = cfg_q;
        ack   = '0;
        if (wr_en) begin
            case (addr)
                OFF_OUT_SET:  cfg_d.out_val = cfg_q.out_val | wbits;
                OFF_OUT_CLR:  cfg_d.out_val = cfg_q.out_val & ~wbits;
                OFF_DIR_SET:  cfg_d.drive   = cfg_q.drive | wbits;
                OFF_DIR_CLR:  cfg_d.drive   = cfg_q.drive & ~wbits;
                OFF_EN_SET:   cfg_d.irq_en  = cfg_q.irq_en | wbits;
                OFF_EN_CLR:   cfg_d.irq_en  = cfg_q.irq_en & ~wbits;
                OFF_MSK_SET:  cfg_d.irq_msk = cfg_q.irq_msk | wbits;
                OFF_MSK_CLR:  cfg_d.irq_msk = cfg_q.irq_msk & ~wbits;
                OFF_EDGE_SET: cfg_d.is_edge = cfg_q.is_edge | wbits;
                OFF_EDGE_CLR: cfg_d.is_edge = cfg_q.is_edge & ~wbits;
                OFF_POL_SET:  cfg_d.pol_hi  = cfg_q.pol_hi | wbits;
                OFF_POL_CLR:  cfg_d.pol_hi  = cfg_q.pol_hi & ~wbits;
                OFF_DEB_SET:  cfg_d.deb_on  = cfg_q.deb_on | wbits;
                OFF_DEB_CLR:  cfg_d.deb_on  = cfg_q.deb_on & ~wbits;
                OFF_BOTH_SET: cfg_d.both_on = cfg_q.both_on | wbits;
                OFF_BOTH_CLR: cfg_d.both_on = cfg_q.both_on & ~wbits;
                OFF_GATE:     cfg_d.gate_on = wdata[0];
                OFF_ACK:      ack           = wbits;
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign out_val = cfg_q.out_val;
    assign drive   = cfg_q.drive;
    assign irq_en  = cfg_q.irq_en;
    assign irq_msk = cfg_q.irq_msk;
    assign is_edge = cfg_q.is_edge;
    assign pol_hi  = cfg_q.pol_hi;
    assign deb_on  = cfg_q.deb_on;
    assign both_on = cfg_q.both_on;
    assign gate_on = cfg_q.gate_on;
endmodule

// File: rtl/gpio_in_filter.sv
module gpio_in_filter #(
    parameter int NLINES     = 32,
    parameter int DEB_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] pin_in,
    input  logic [NLINES-1:0] deb_on,
    output logic [NLINES-1:0] level
);
    localparam int CNT_W = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

    typedef struct packed {
        logic [NLINES-1:0]            meta;
        logic [NLINES-1:0]            sync;
        logic [NLINES-1:0]            flt;
        logic [NLINES-1:0][CNT_W-1:0] cnt;
    } flt_t;

    flt_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin_in;
        st_d.sync = st_q.meta;
        for (int i = 0; i < NLINES; i++) begin
            if (!deb_on[i]) begin
                st_d.flt[i] = st_q.sync[i];
                st_d.cnt[i] = '0;
            end else if (st_q.sync[i] == st_q.flt[i]) begin
                st_d.cnt[i] = '0;
            end else if (st_q.cnt[i] == CNT_LAST) begin
                st_d.flt[i] = st_q.sync[i];
                st_d.cnt[i] = '0;
            end else begin
                st_d.cnt[i] = st_q.cnt[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.flt;
endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit #(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] level,
    input  logic [NLINES-1:0] irq_en,
    input  logic [NLINES-1:0] irq_msk,
    input  logic [NLINES-1:0] is_edge,
    input  logic [NLINES-1:0] pol_hi,
    input  logic [NLINES-1:0] both_on,
    input  logic [NLINES-1:0] ack,
    output logic [NLINES-1:0] pend
);
    typedef struct packed {
        logic [NLINES-1:0] prev;
        logic [NLINES-1:0] held;
    } evt_t;

    evt_t ev_d, ev_q;
    logic [NLINES-1:0] rise, fall, hit;

    always_comb begin
        rise = level & ~ev_q.prev;
        fall = ~level & ev_q.prev;
        for (int i = 0; i < NLINES; i++) begin
            if (both_on[i])      hit[i] = rise[i] | fall[i];
            else if (is_edge[i]) hit[i] = pol_hi[i] ? rise[i] : fall[i];
            else                 hit[i] = 1'b0;
        end
        ev_d.prev = level;
        ev_d.held = (ev_q.held & ~ack) | (hit & irq_en);
        for (int i = 0; i < NLINES; i++) begin
            if (both_on[i] || is_edge[i]) pend[i] = ev_q.held[i];
            else                          pend[i] = ~(level[i] ^ pol_hi[i]);
        end
        pend = pend & irq_en & ~irq_msk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NLINES     = 32,
    parameter int DEB_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic [NLINES-1:0] pin_in,
    output logic [NLINES-1:0] pin_out,
    output logic [NLINES-1:0] pin_oe,
    output logic              irq_out
);
    typedef struct packed {
        logic [BUS_W-1:0] rdata;
    } rd_t;

    logic [NLINES-1:0] irq_en, irq_msk, is_edge, pol_hi, deb_on, both_on, ack;
    logic [NLINES-1:0] level, pend;
    logic              gate_on;
    rd_t               rd_d, rd_q;

    gpio_cfg_regs #(.NLINES(NLINES)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .out_val(pin_out), .drive(pin_oe), .irq_en(irq_en), .irq_msk(irq_msk),
        .is_edge(is_edge), .pol_hi(pol_hi), .deb_on(deb_on), .both_on(both_on),
        .gate_on(gate_on), .ack(ack)
    );

    gpio_in_filter #(.NLINES(NLINES), .DEB_CYCLES(DEB_CYCLES)) u_flt (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .deb_on(deb_on), .level(level)
    );

    gpio_evt_unit #(.NLINES(NLINES)) u_evt (
        .clk(clk), .rst_n(rst_n), .level(level), .irq_en(irq_en),
        .irq_msk(irq_msk), .is_edge(is_edge), .pol_hi(pol_hi),
        .both_on(both_on), .ack(ack), .pend(pend)
    );

    always_comb begin
        rd_d.rdata = '0;
        if (rd_en) begin
            case (addr)
                OFF_DIR_RD:  rd_d.rdata = BUS_W'(pin_oe);
                OFF_PEND_RD: rd_d.rdata = BUS_W'(pend);
                OFF_PIN_RD:  rd_d.rdata = BUS_W'(level);
                OFF_GATE:    rd_d.rdata = BUS_W'(gate_on);
                OFF_BOTH_RD: rd_d.rdata = BUS_W'(both_on);
                default:     rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata   = rd_q.rdata;
    assign irq_out = gate_on & (|pend);
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int NLINES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [BUS_W-1:0]  wdata,
    input logic [BUS_W-1:0]  rdata,
    input logic [NLINES-1:0] pin_oe,
    input logic              gate_on,
    input logic              irq_out
);
    // R2
    dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_DIR_SET) |=>
            ((pin_oe & $past(wdata[NLINES-1:0])) == $past(wdata[NLINES-1:0])));

    // R2
    dir_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_DIR_CLR) |=> ((pin_oe & $past(wdata[NLINES-1:0])) == '0));

    // R2
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pin_oe));

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> gate_on);

    // R10
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_GATE && !wdata[0]) |=> !irq_out);

    // R11
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NLINES(NLINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_oe(pin_oe), .gate_on(gate_on),
    .irq_out(irq_out)
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
    localparam int N   = 32;
    localparam int DEB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out, pin_oe;
    logic        irq_out;

    int    n_chk = 0, n_bad = 0;
    bit    chk_on = 1'b0, done = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    gpio_irq_ctrl #(.NLINES(N), .DEB_CYCLES(DEB)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq_out(irq_out)
    );

    // behavioural reference state
    logic [31:0] m_s1, m_s2, m_lv, m_pv, m_hold, m_out, m_dir, m_en, m_msk;
    logic [31:0] m_edge, m_pol, m_deb, m_both, m_rd;
    bit          m_gate;
    int          m_cnt [32];

    function automatic logic [31:0] m_pending();
        logic [31:0] p = '0;
        for (int i = 0; i < N; i++) begin
            bit act;
            if (m_both[i] || m_edge[i]) act = m_hold[i];
            else act = m_pol[i] ? m_lv[i] : !m_lv[i];
            p[i] = act && m_en[i] && !m_msk[i];
        end
        return p;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h18: return m_dir;
            8'h70: return m_pending();
            8'h80: return m_lv;
            8'hA0: return {31'b0, m_gate};
            8'hB8: return m_both;
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_s1, m_s2, m_lv, m_pv, m_hold, m_out, m_dir, m_en, m_msk} = '0;
            {m_edge, m_pol, m_deb, m_both, m_rd} = '0;
            m_gate = 0;
            for (int i = 0; i < 32; i++) m_cnt[i] = 0;
        end else begin
            logic [31:0] n_lv, n_hold, ackv;
            n_lv = m_lv;
            ackv = (wr_en && addr == 8'h78) ? wdata : '0;
            for (int i = 0; i < N; i++) begin
                bit up, dn, ev;
                up = m_lv[i] && !m_pv[i];
                dn = !m_lv[i] && m_pv[i];
                if (m_both[i]) ev = up || dn;
                else if (m_edge[i]) ev = m_pol[i] ? up : dn;
                else ev = 0;
                n_hold[i] = (m_hold[i] && !ackv[i]) || (ev && m_en[i]);
                if (!m_deb[i]) begin
                    n_lv[i] = m_s2[i]; m_cnt[i] = 0;
                end else if (m_s2[i] == m_lv[i]) begin
                    m_cnt[i] = 0;
                end else if (m_cnt[i] == DEB - 1) begin
                    n_lv[i] = m_s2[i]; m_cnt[i] = 0;
                end else begin
                    m_cnt[i]++;
                end
            end
            m_rd   = rd_en ? m_read(addr) : '0;
            m_pv   = m_lv;
            m_lv   = n_lv;
            m_hold = n_hold;
            m_s2   = m_s1;
            m_s1   = pin_in;
            if (wr_en) begin
                case (addr)
                    8'h00: m_out  |= wdata;  8'h04: m_out  &= ~wdata;
                    8'h10: m_dir  |= wdata;  8'h14: m_dir  &= ~wdata;
                    8'h20: m_en   |= wdata;  8'h24: m_en   &= ~wdata;
                    8'h30: m_msk  |= wdata;  8'h34: m_msk  &= ~wdata;
                    8'h40: m_edge |= wdata;  8'h44: m_edge &= ~wdata;
                    8'h50: m_pol  |= wdata;  8'h54: m_pol  &= ~wdata;
                    8'h60: m_deb  |= wdata;  8'h64: m_deb  &= ~wdata;
                    8'hB0: m_both |= wdata;  8'hB4: m_both &= ~wdata;
                    8'hA0: m_gate = wdata[0];
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (chk_on && !done) begin
            bit exp_irq;
            exp_irq = m_gate && (m_pending() != 0);
            n_chk++;
            if (rdata !== m_rd) begin
                n_bad++;
                $display("FAIL %s rdata act=%h exp=%h", cur_req, rdata, m_rd);
            end
            if (pin_out !== m_out || pin_oe !== m_dir) begin
                n_bad++;
                $display("FAIL %s pins act=%h/%h exp=%h/%h", cur_req, pin_out, pin_oe, m_out, m_dir);
            end
            if (irq_out !== exp_irq) begin
                n_bad++;
                $display("FAIL %s irq_out act=%b exp=%b", cur_req, irq_out, exp_irq);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1;
        chk_on = 1;
        // R1 reset values
        cur_req = "R1";
        rd(8'h18); rd(8'h70); rd(8'h80); rd(8'hA0); rd(8'hB8);
        // R2 set/clear pairs
        cur_req = "R2";
        wr(8'h00, 32'hA5A5_0F0F); wr(8'h04, 32'h0000_000F); wr(8'h00, 32'h0);
        wr(8'h10, 32'hFFFF_0000); wr(8'h14, 32'h00F0_0000); rd(8'h18);
        // R11 write-only and unmapped offsets
        cur_req = "R11";
        rd(8'h00); rd(8'hFC); rd(8'h78);
        // R3 synchronised pin read
        cur_req = "R3";
        @(negedge clk); pin_in = 32'h1234_5678;
        rd(8'h80); rd(8'h80); idle(2); rd(8'h80);
        pin_in = 32'h0;
        idle(4);
        // R4 debounce: glitch then stable change
        cur_req = "R4";
        wr(8'h60, 32'h0000_00FF);
        @(negedge clk); pin_in[0] = 1; idle(2); pin_in[0] = 0;
        for (int i = 0; i < 8; i++) rd(8'h80);
        pin_in[1] = 1;
        for (int i = 0; i < 8; i++) rd(8'h80);
        pin_in[1] = 0; idle(10);
        wr(8'h64, 32'h0000_00FF);
        // R5 level high on line 4, level low on line 5
        cur_req = "R5";
        wr(8'hA0, 32'h1);
        wr(8'h50, 32'h0000_0010); wr(8'h20, 32'h0000_0030);
        rd(8'h70);
        pin_in[4] = 1; pin_in[5] = 1; idle(4); rd(8'h70);
        pin_in[4] = 0; idle(4); rd(8'h70);
        wr(8'h24, 32'h0000_0030); pin_in[5] = 0;
        // R6 rising on line 8, falling on line 9
        cur_req = "R6";
        wr(8'h40, 32'h0000_0300); wr(8'h50, 32'h0000_0100); wr(8'h20, 32'h0000_0300);
        pin_in[8] = 1; idle(5); pin_in[8] = 0; idle(5); rd(8'h70);
        wr(8'h78, 32'h0000_0100); rd(8'h70);
        pin_in[9] = 1; idle(5); rd(8'h70); pin_in[9] = 0; idle(5); rd(8'h70);
        wr(8'h78, 32'h0000_0200); rd(8'h70);
        // R7 dual-edge override on line 8
        cur_req = "R7";
        wr(8'hB0, 32'h0000_0100); rd(8'hB8);
        pin_in[8] = 1; idle(5); wr(8'h78, 32'h100);
        pin_in[8] = 0; idle(5); rd(8'h70);
        wr(8'h78, 32'h100); wr(8'hB4, 32'h0000_0100); rd(8'hB8);
        // R8 acknowledge meeting an edge, and zero ack bits
        cur_req = "R8";
        for (int k = 0; k < 7; k++) begin
            pin_in[8] = ~pin_in[8];
            idle(k);
            wr(8'h78, 32'h0000_0100);
            idle(4); rd(8'h70);
            wr(8'h78, 32'h0000_0100);
        end
        pin_in[8] = 1; idle(5);
        pin_in[8] = 0; idle(5);
        pin_in[8] = 1; idle(5);
        wr(8'h78, 32'hFFFF_FEFF); rd(8'h70);
        wr(8'h78, 32'h100);
        // R9 mask and enable gating
        cur_req = "R9";
        wr(8'h30, 32'h0000_0100);
        pin_in[8] = 0; idle(5); pin_in[8] = 1; idle(5); rd(8'h70);
        wr(8'h34, 32'h0000_0100); rd(8'h70);
        wr(8'h78, 32'h100);
        wr(8'h24, 32'h0000_0200);
        pin_in[9] = 1; idle(5); pin_in[9] = 0; idle(5);
        wr(8'h20, 32'h0000_0200); rd(8'h70);
        // R10 combined gate
        cur_req = "R10";
        pin_in[8] = 0; idle(5); pin_in[8] = 1; idle(5);
        wr(8'hA0, 32'h0); rd(8'hA0); idle(2);
        wr(8'hA0, 32'h1); rd(8'hA0); idle(2);
        wr(8'h78, 32'hFFFF_FFFF); idle(3);
        finish_run();
    end
endmodule